// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Multicycle Datapath

This block steers a multicycle processor datapath from a small microprogram instead of a hand-built next-state network. A micro-address register selects one word of a constant control store. Each word carries every datapath control field plus a two-bit sequencing code. The sequencing code tells the address-select logic where the next micro-address comes from. There are four sources: fetch (address zero), the current address plus one, and two opcode-indexed dispatch tables.

The first dispatch table is consulted at the end of decode. It sends R-format, branch-on-equal, jump and memory instructions to their first execution step. The second table is consulted after the memory address has been formed, and splits loads from stores. The opcode comes from the instruction register of the datapath. The datapath itself is outside this block.

Top module: `ucode_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the micro-address is 0 and the outputs show the fetch word. Fetch drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `alu_b_sel`=01, and 0 on every other output. A reset during an instruction also returns to fetch.
- R2: Fetch (address 0) is followed by decode (address 1). Decode drives `alu_b_sel`=11 and 0 on every other output.
- R3: From decode, the next address comes from the first dispatch table, looked up with `opcode`. The table entries are: 000000 goes to 6, 000010 goes to 9, 000100 goes to 8, and 100011 and 101011 both go to 2.
- R4: Address 2 drives `alu_a_sel`=1, `alu_b_sel`=10 and 0 elsewhere. The next address comes from the second dispatch table: 100011 goes to 3 and 101011 goes to 5.
- R5: A load runs through addresses 0,1,2,3,4 and then 0. Address 3 drives `mem_rd`=1 and `addr_sel`=1. Address 4 drives `reg_wr`=1, `wb_sel`=1 and `dst_sel`=0. All other outputs are 0 in both steps.
- R6: A store runs through 0,1,2,5 and then 0. Address 5 drives `mem_wr`=1, `addr_sel`=1 and 0 elsewhere.
- R7: An R-format instruction runs through 0,1,6,7 and then 0. Address 6 drives `alu_a_sel`=1 and `alu_op`=10. Address 7 drives `reg_wr`=1 and `dst_sel`=1. All other outputs are 0 in both steps.
- R8: A branch runs through 0,1,8 and then 0. Address 8 drives `alu_a_sel`=1, `alu_op`=01, `pc_wr_cond`=1, `pc_src`=01 and 0 elsewhere.
- R9: A jump runs through 0,1,9 and then 0. Address 9 drives `pc_wr`=1, `pc_src`=10 and 0 elsewhere.
- R10: An opcode that is missing from the table being consulted selects address 0. This holds for both dispatch tables.
- R11: `mem_rd`, `mem_wr` and `reg_wr` are never high together in pairs, and `pc_wr` is never high together with `pc_wr_cond`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; forces micro-address 0 |
| opcode | input | 6 | Opcode field of the held instruction |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional program counter load |
| pc_wr_cond | output | 1 | Program counter load when the ALU reports equal |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| alu_a_sel | output | 1 | ALU A operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 extended immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| reg_wr | output | 1 | Register file write |
| dst_sel | output | 1 | Destination register: 0 rt field, 1 rd field |
| wb_sel | output | 1 | Write-back data: 0 ALU result register, 1 memory data register |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume the datapath holds `opcode` steady from decode through the second dispatch. The successor checks therefore list only the targets that the tables can produce.

The stimulus changes `opcode` only while the sequencer sits in fetch. There is one exception: a directed case swaps the opcode between the first and second dispatch. That case shows a miss in the second table, and its expected result (fetch) is still among the successors the checker allows.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  localparam int OPC_W = 6;
  localparam int UADR_W = 4;

  localparam logic [OPC_W-1:0] OPC_RFMT  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;

  // micro-address map
  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_MADDR  = 2;
  localparam int UA_LDRD   = 3;
  localparam int UA_LDWB   = 4;
  localparam int UA_STWR   = 5;
  localparam int UA_REXE   = 6;
  localparam int UA_RWB    = 7;
  localparam int UA_BEQ    = 8;
  localparam int UA_JUMP   = 9;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_DISP1 = 2'b01,
    SEQ_DISP2 = 2'b10,
    SEQ_INCR  = 2'b11
  } seq_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       reg_wr;
    logic       dst_sel;
    logic       wb_sel;
  } ctrl_t;

  typedef struct packed {
    ctrl_t ctrl;
    seq_e  seq;
  } uword_t;

  function automatic ctrl_t ctrl_idle();
    ctrl_t c;
    c = '0;
    return c;
  endfunction

endpackage

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
#(
  parameter int UA_W = ucode_pkg::UADR_W
) (
  input  logic [UA_W-1:0] upc,
  output uword_t          word
);

  function automatic uword_t store_entry(input logic [UA_W-1:0] a);
    uword_t w;
    w.ctrl = ctrl_idle();
    w.seq  = SEQ_FETCH;
    case (int'(a))
      UA_FETCH: begin
        w.ctrl.mem_rd    = 1'b1;
        w.ctrl.ir_wr     = 1'b1;
        w.ctrl.pc_wr     = 1'b1;
        w.ctrl.alu_b_sel = 2'b01;
        w.seq            = SEQ_INCR;
      end
      UA_DECODE: begin
        w.ctrl.alu_b_sel = 2'b11;
        w.seq            = SEQ_DISP1;
      end
      UA_MADDR: begin
        w.ctrl.alu_a_sel = 1'b1;
        w.ctrl.alu_b_sel = 2'b10;
        w.seq            = SEQ_DISP2;
      end
      UA_LDRD: begin
        w.ctrl.mem_rd   = 1'b1;
        w.ctrl.addr_sel = 1'b1;
        w.seq           = SEQ_INCR;
      end
      UA_LDWB: begin
        w.ctrl.reg_wr = 1'b1;
        w.ctrl.wb_sel = 1'b1;
      end
      UA_STWR: begin
        w.ctrl.mem_wr   = 1'b1;
        w.ctrl.addr_sel = 1'b1;
      end
      UA_REXE: begin
        w.ctrl.alu_a_sel = 1'b1;
        w.ctrl.alu_op    = 2'b10;
        w.seq            = SEQ_INCR;
      end
      UA_RWB: begin
        w.ctrl.reg_wr  = 1'b1;
        w.ctrl.dst_sel = 1'b1;
      end
      UA_BEQ: begin
        w.ctrl.alu_a_sel  = 1'b1;
        w.ctrl.alu_op     = 2'b01;
        w.ctrl.pc_wr_cond = 1'b1;
        w.ctrl.pc_src     = 2'b01;
      end
      UA_JUMP: begin
        w.ctrl.pc_wr  = 1'b1;
        w.ctrl.pc_src = 2'b10;
      end
      default: begin
        w.ctrl = ctrl_idle();
        w.seq  = SEQ_FETCH;
      end
    endcase
    return w;
  endfunction

  always_comb word = store_entry(upc);

endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_pkg::*;
#(
  parameter int OP_W  = ucode_pkg::OPC_W,
  parameter int UA_W  = ucode_pkg::UADR_W,
  parameter int TABLE = 1
) (
  input  logic [OP_W-1:0] opcode,
  output logic            hit,
  output logic [UA_W-1:0] target
);

  generate
    if (TABLE == 1) begin : g_first
      always_comb begin
        hit    = 1'b1;
        target = '0;
        if (opcode == OP_W'(OPC_RFMT))       target = UA_W'(UA_REXE);
        else if (opcode == OP_W'(OPC_JUMP))  target = UA_W'(UA_JUMP);
        else if (opcode == OP_W'(OPC_BEQ))   target = UA_W'(UA_BEQ);
        else if (opcode == OP_W'(OPC_LOAD) ||
                 opcode == OP_W'(OPC_STORE)) target = UA_W'(UA_MADDR);
        else                                 hit    = 1'b0;
      end
    end else begin : g_second
      always_comb begin
        hit    = 1'b1;
        target = '0;
        if (opcode == OP_W'(OPC_LOAD))       target = UA_W'(UA_LDRD);
        else if (opcode == OP_W'(OPC_STORE)) target = UA_W'(UA_STWR);
        else                                 hit    = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/ucode_next.sv
module ucode_next
  import ucode_pkg::*;
#(
  parameter int UA_W = ucode_pkg::UADR_W
) (
  input  logic [UA_W-1:0] upc,
  input  seq_e            seq,
  input  logic            d1_hit,
  input  logic [UA_W-1:0] d1_addr,
  input  logic            d2_hit,
  input  logic [UA_W-1:0] d2_addr,
  output logic [UA_W-1:0] upc_nxt
);

  function automatic logic [UA_W-1:0] pick_next(
    input logic [UA_W-1:0] cur,
    input seq_e            s,
    input logic            h1,
    input logic [UA_W-1:0] a1,
    input logic            h2,
    input logic [UA_W-1:0] a2
  );
    logic [UA_W-1:0] n;
    case (s)
      SEQ_INCR:  n = cur + UA_W'(1);
      SEQ_DISP1: n = h1 ? a1 : '0;
      SEQ_DISP2: n = h2 ? a2 : '0;
      default:   n = '0;
    endcase
    return n;
  endfunction

  always_comb upc_nxt = pick_next(upc, seq, d1_hit, d1_addr, d2_hit, d2_addr);

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int OP_W = ucode_pkg::OPC_W,
  parameter int UA_W = ucode_pkg::UADR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            addr_sel,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic [1:0]      alu_op,
  output logic [1:0]      pc_src,
  output logic            reg_wr,
  output logic            dst_sel,
  output logic            wb_sel
);

  logic [UA_W-1:0] upc;
  logic [UA_W-1:0] upc_nxt;
  uword_t          word;
  seq_e            seq_sel;
  logic            d1_hit;
  logic            d2_hit;
  logic [UA_W-1:0] d1_addr;
  logic [UA_W-1:0] d2_addr;

  ucode_store #(.UA_W(UA_W)) u_store (
    .upc  (upc),
    .word (word)
  );

  assign seq_sel = word.seq;

  ucode_dispatch #(.OP_W(OP_W), .UA_W(UA_W), .TABLE(1)) u_disp1 (
    .opcode (opcode),
    .hit    (d1_hit),
    .target (d1_addr)
  );

  ucode_dispatch #(.OP_W(OP_W), .UA_W(UA_W), .TABLE(2)) u_disp2 (
    .opcode (opcode),
    .hit    (d2_hit),
    .target (d2_addr)
  );

  ucode_next #(.UA_W(UA_W)) u_next (
    .upc     (upc),
    .seq     (seq_sel),
    .d1_hit  (d1_hit),
    .d1_addr (d1_addr),
    .d2_hit  (d2_hit),
    .d2_addr (d2_addr),
    .upc_nxt (upc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= upc_nxt;
  end

  assign mem_rd     = word.ctrl.mem_rd;
  assign mem_wr     = word.ctrl.mem_wr;
  assign ir_wr      = word.ctrl.ir_wr;
  assign pc_wr      = word.ctrl.pc_wr;
  assign pc_wr_cond = word.ctrl.pc_wr_cond;
  assign addr_sel   = word.ctrl.addr_sel;
  assign alu_a_sel  = word.ctrl.alu_a_sel;
  assign alu_b_sel  = word.ctrl.alu_b_sel;
  assign alu_op     = word.ctrl.alu_op;
  assign pc_src     = word.ctrl.pc_src;
  assign reg_wr     = word.ctrl.reg_wr;
  assign dst_sel    = word.ctrl.dst_sel;
  assign wb_sel     = word.ctrl.wb_sel;

endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk #(
  parameter int OP_W = 6,
  parameter int UA_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] opcode,
  input logic [UA_W-1:0] upc,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            reg_wr,
  input logic            pc_wr,
  input logic            pc_wr_cond
);

  // R1
  reset_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (upc == UA_W'(0)));

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_W'(0)) |=> (upc == UA_W'(1)));

  // R3
  decode_targets_chk: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_W'(1)) |=> (upc inside {UA_W'(0), UA_W'(2), UA_W'(6), UA_W'(8), UA_W'(9)}));

  // R3
  rfmt_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_W'(1) && opcode == OP_W'(0)) |=> (upc == UA_W'(6)));

  // R4
  maddr_targets_chk: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_W'(2)) |=> (upc inside {UA_W'(0), UA_W'(3), UA_W'(5)}));

  // R5
  load_read_chk: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_W'(3)) |=> (upc == UA_W'(4) && reg_wr));

  // R7
  rexe_chk: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_W'(6)) |=> (upc == UA_W'(7)));

  // R6
  store_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (upc == UA_W'(0)));

  // R10
  unmapped_op_chk: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_W'(1) && !(opcode inside {OP_W'(0), OP_W'(2), OP_W'(4), OP_W'(35), OP_W'(43)}))
    |=> (upc == UA_W'(0)));

  // R11
  mem_reg_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, reg_wr}));

  // R11
  pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr && pc_wr_cond));

endmodule

bind ucode_seq ucode_seq_chk #(.OP_W(OP_W), .UA_W(UA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opcode     (opcode),
  .upc        (upc),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .reg_wr     (reg_wr),
  .pc_wr      (pc_wr),
  .pc_wr_cond (pc_wr_cond)
);

// File: tb/ucode_seq_test.sv
module ucode_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b000000;
  logic       mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, addr_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic       reg_wr, dst_sel, wb_sel;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ucode_seq uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
    .reg_wr(reg_wr), .dst_sel(dst_sel), .wb_sel(wb_sel)
  );

  // packed observation, order: rd wr ir pc pcc adr a b[2] op[2] src[2] rw dst wb
  function automatic logic [15:0] seen();
    return {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, addr_sel, alu_a_sel,
            alu_b_sel, alu_op, pc_src, reg_wr, dst_sel, wb_sel};
  endfunction

  function automatic logic [15:0] mk(
    input bit rd, input bit wr, input bit ir, input bit pc, input bit pcc,
    input bit adr, input bit a, input bit [1:0] b, input bit [1:0] op,
    input bit [1:0] src, input bit rw, input bit dst, input bit wb);
    return {rd, wr, ir, pc, pcc, adr, a, b, op, src, rw, dst, wb};
  endfunction

  function automatic logic [15:0] expect_at(input int ua);
    case (ua)
      0: return mk(1,0,1,1,0, 0,0,2'b01,2'b00,2'b00, 0,0,0);
      1: return mk(0,0,0,0,0, 0,0,2'b11,2'b00,2'b00, 0,0,0);
      2: return mk(0,0,0,0,0, 0,1,2'b10,2'b00,2'b00, 0,0,0);
      3: return mk(1,0,0,0,0, 1,0,2'b00,2'b00,2'b00, 0,0,0);
      4: return mk(0,0,0,0,0, 0,0,2'b00,2'b00,2'b00, 1,0,1);
      5: return mk(0,1,0,0,0, 1,0,2'b00,2'b00,2'b00, 0,0,0);
      6: return mk(0,0,0,0,0, 0,1,2'b00,2'b10,2'b00, 0,0,0);
      7: return mk(0,0,0,0,0, 0,0,2'b00,2'b00,2'b00, 1,1,0);
      8: return mk(0,0,0,0,1, 0,1,2'b00,2'b01,2'b01, 0,0,0);
      9: return mk(0,0,0,1,0, 0,0,2'b00,2'b00,2'b10, 0,0,0);
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input int ua);
    logic [15:0] got;
    logic [15:0] exp;
    got = seen();
    exp = expect_at(ua);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s step ua=%0d got=%b expected=%b", req, ua, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // walks a micro-address path, n entries, starting at fetch
  task automatic run_path(input string req, input logic [5:0] op, input int n,
                          input int p0, input int p1, input int p2,
                          input int p3, input int p4, input int p5);
    int path [6];
    path = '{p0, p1, p2, p3, p4, p5};
    opcode = op;
    for (int i = 0; i < n; i++) begin
      check(req, path[i]);
      if (i < n - 1) step();
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    check("R1", 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", 0);
  endtask

  task automatic t_load();   run_path("R5", 6'b100011, 6, 0, 1, 2, 3, 4, 0); endtask
  task automatic t_store();  run_path("R6", 6'b101011, 5, 0, 1, 2, 5, 0, 0); endtask
  task automatic t_rfmt();   run_path("R7", 6'b000000, 5, 0, 1, 6, 7, 0, 0); endtask
  task automatic t_branch(); run_path("R8", 6'b000100, 4, 0, 1, 8, 0, 0, 0); endtask
  task automatic t_jump();   run_path("R9", 6'b000010, 4, 0, 1, 9, 0, 0, 0); endtask

  task automatic t_disp1_miss();
    run_path("R10", 6'b111111, 3, 0, 1, 0, 0, 0, 0);
    run_path("R10", 6'b001000, 3, 0, 1, 0, 0, 0, 0);
  endtask

  // R4 and R10: the second table gets an opcode it does not hold
  task automatic t_disp2_miss();
    run_path("R4", 6'b100011, 3, 0, 1, 2, 0, 0, 0);
    opcode = 6'b000100;
    step();
    check("R10", 0);
  endtask

  // R1: reset in the middle of an R-format instruction
  task automatic t_mid_reset();
    run_path("R3", 6'b000000, 3, 0, 1, 6, 0, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    step();
    check("R1", 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R2", 0);
    step();
    check("R2", 1);
    step();
    check("R3", 6);
    step();
    check("R7", 7);
    step();
    check("R2", 0);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_store();
    t_rfmt();
    t_branch();
    t_jump();
    t_disp1_miss();
    t_disp2_miss();
    t_mid_reset();
    t_load();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule